// File: doc/BRIEF.md
# Checkpointing Block-Remap Translation Table

This block keeps memory crash-consistent with no help from software. It tracks memory at cache-block granularity. Each tracked block has one table entry that holds two non-volatile slot numbers. The working slot receives the current epoch's writes. The checkpoint slot holds the copy from the last completed commit. A write never copies data. It is steered to a freshly allocated slot and the entry is updated to point at that slot, so the checkpointed copy stays intact until the next commit retires it.

Execution runs in epochs. A commit strobe closes the current epoch at once and starts a background walk that visits one table entry per cycle. For every entry written in the closed epoch, the walk promotes the working slot to checkpoint slot and returns the old checkpoint slot to the free pool. Requests keep flowing during the walk. A recovery strobe rolls every block back to its last committed copy and returns the discarded working slots to the pool. If recovery is requested during a walk, it waits for the walk to finish, so the commit that was already taken is kept. The block does not accept a write to an untracked tag while every entry is in use.

Top module: `ckpt_remap_table`

## Requirements
- R1: After reset no tag is tracked, every slot is free, `busy` is low, `rsp_valid` is low, and `req_ready` is high.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` high) produces exactly one response with `rsp_valid` high in the next cycle. `rsp_hit` is high when the tag was already tracked. A write to an untracked tag takes the lowest-numbered free slot and returns that slot in `rsp_slot`.
- R3: A second write to a block in the epoch that wrote it last reuses the same working slot and allocates nothing.
- R4: A read of a tracked block returns the working slot if the block was written in the current epoch or in the epoch being committed, and the checkpoint slot otherwise. A read of an untracked tag returns `rsp_hit` low.
- R5: A commit strobe while idle raises `busy` for exactly ENTRIES cycles. During that time every block written in the closed epoch has its old checkpoint slot freed and its working slot made the checkpoint slot.
- R6: The first write to a committed block in a new epoch gets the lowest free slot. The checkpoint slot stays allocated until a later commit replaces it.
- R7: Reads and writes are accepted while a commit walk is in progress. A write to a block still waiting in the walk folds that block's commit into the write.
- R8: A commit strobe that arrives while `busy` is high is held. `busy` stays high without a gap until the held walk ends, so two overlapping commits give 2×ENTRIES busy cycles.
- R9: A recovery strobe while idle takes effect on the next edge. Every working slot written since the last commit is freed. Each block reverts to its checkpoint slot, and a block that was never committed becomes untracked.
- R10: A recovery strobe during a commit walk is applied only after the walk completes. Blocks committed by that walk keep their new checkpoint slot.
- R11: A write that needs a new slot while no slot is free holds `req_ready` low and produces no response. It is accepted as soon as a commit walk frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Block address of the request |
| req_ready | output | 1 | Request is accepted on this edge when `req_valid` is high |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_hit | output | 1 | The tag was tracked when the request was accepted |
| rsp_slot | output | $clog2(SLOTS) | Slot read from or written to |
| commit_req | input | 1 | Close the current epoch and checkpoint it |
| recover_req | input | 1 | Roll back to the last completed checkpoint |
| busy | output | 1 | A commit walk is running or a commit or recovery is waiting |

## Verification
The hardest situations to reach are the overlaps: a write landing on a block during a commit walk, a recovery queued behind a walk, and a stall on an empty free pool. Each one depends on the exact cycle at which the walk index passes a given entry. The bench uses a small slot pool so the pool can be drained with a few writes. It then times writes and strobes against the known walk progress of one entry per cycle, checks the slot returned, and reads back which slots were freed through the lowest-free allocation order.

// File: rtl/ckrt_pkg.sv
// Shared types for the checkpointing remap table.
package ckrt_pkg;

    // What a write does to the entry it targets
    typedef enum logic [1:0] {
        WK_NEW      = 2'd0,  // untracked tag: claim an entry and a slot
        WK_IN_PLACE = 2'd1,  // already written this epoch: reuse working slot
        WK_REMAP    = 2'd2,  // committed block: fresh working slot
        WK_FOLD     = 2'd3   // block awaiting the walk: commit inline, then remap
    } wr_kind_e;

endpackage

// File: rtl/ckrt_slot_alloc.sv
// Free-slot pool kept as a bitmap.
// Grants the lowest-numbered free slot. Any number of slots may be
// returned in one cycle. Assumes take_mask is either zero or equal to
// grant_mask, and that free_mask only names slots that are in use.
module ckrt_slot_alloc #(
    parameter int SLOTS  = 32,
    localparam int SLOT_W = $clog2(SLOTS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOTS-1:0]  take_mask,
    input  logic [SLOTS-1:0]  free_mask,
    output logic              avail,
    output logic [SLOT_W-1:0] grant_idx,
    output logic [SLOTS-1:0]  grant_mask
);

    logic [SLOTS-1:0] free_map;

    // Pick the lowest set bit of the free map
    always_comb begin
        grant_idx = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (free_map[k]) grant_idx = SLOT_W'(k);
        end
        avail      = |free_map;
        grant_mask = avail ? (SLOTS'(1) << grant_idx) : '0;
    end

    // Pool update: remove the granted slot, add the returned slots
    always_ff @(posedge clk) begin
        if (!rst_n) free_map <= '1;
        else        free_map <= (free_map & ~take_mask) | free_mask;
    end

endmodule

// File: rtl/ckrt_tag_match.sv
// Fully associative lookup over the entry tags.
// Returns the matching entry (at most one by construction of the table)
// and the lowest-numbered invalid entry for new tags.
module ckrt_tag_match #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
    input  logic [ENTRIES-1:0]            valid_vec,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tag_vec,
    input  logic [TAG_W-1:0]              key,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx,
    output logic                          room,
    output logic [IDX_W-1:0]              room_idx
);

    logic [ENTRIES-1:0] match;

    // Per-entry comparators
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_vec[g] && (tag_vec[g] == key);
    end

    // Encode the match and the first free entry
    always_comb begin
        hit_idx  = '0;
        room_idx = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (match[k])      hit_idx  = IDX_W'(k);
            if (!valid_vec[k]) room_idx = IDX_W'(k);
        end
        hit  = |match;
        room = ~&valid_vec;
    end

endmodule

// File: rtl/ckrt_commit_seq.sv
// Epoch counter and commit/recovery sequencer.
// A commit advances the epoch at once and walks the entries one per cycle.
// A commit or recovery that arrives during a walk is held. Held commits
// run before a held recovery. Recovery is applied in a single cycle.
module ckrt_commit_seq #(
    parameter int ENTRIES = 16,
    parameter int EPOCH_W = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_req,
    input  logic               recover_req,
    output logic               walking,
    output logic [IDX_W-1:0]   walk_idx,
    output logic [EPOCH_W-1:0] cur_ep,
    output logic [EPOCH_W-1:0] commit_ep,
    output logic               rec_apply,
    output logic               busy
);

    logic cpend;
    logic rpend;
    logic want_commit;
    logic last;

    // Decode pending work
    always_comb begin
        want_commit = commit_req || cpend;
        last        = (walk_idx == IDX_W'(ENTRIES - 1));
        rec_apply   = (recover_req || rpend) && !walking && !want_commit;
        busy        = walking || cpend || rpend;
    end

    // Walk progress, epoch advance and held commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walking   <= 1'b0;
            walk_idx  <= '0;
            cur_ep    <= '0;
            commit_ep <= '0;
            cpend     <= 1'b0;
        end else if (walking && !last) begin
            walk_idx <= walk_idx + 1'b1;
            cpend    <= cpend || commit_req;
        end else if (want_commit) begin
            walking   <= 1'b1;
            walk_idx  <= '0;
            commit_ep <= cur_ep;
            cur_ep    <= cur_ep + 1'b1;
            cpend     <= 1'b0;
        end else begin
            walking <= 1'b0;
        end
    end

    // Held recovery flag
    always_ff @(posedge clk) begin
        if (!rst_n) rpend <= 1'b0;
        else        rpend <= (rpend || recover_req) && !rec_apply;
    end

endmodule

// File: rtl/ckpt_remap_table.sv
// Checkpointing block-remap translation table (top).
// Each entry tracks one block: a working slot, a checkpoint slot, a flag
// for an existing checkpoint, a pending flag and the epoch of the last
// write. Writes are steered to fresh slots. The commit walk and recovery
// retire slots to the pool. Assumes the slot contents live elsewhere; this
// block only decides slot numbers.
module ckpt_remap_table
    import ckrt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int SLOTS   = 32,
    parameter int TAG_W   = 20,
    parameter int EPOCH_W = 3,
    localparam int SLOT_W = $clog2(SLOTS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SLOT_W-1:0] rsp_slot,
    input  logic              commit_req,
    input  logic              recover_req,
    output logic              busy
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic               valid;
        logic [TAG_W-1:0]   tag;
        logic [SLOT_W-1:0]  wslot;
        logic [SLOT_W-1:0]  cslot;
        logic               cvalid;
        logic               pend;
        logic [EPOCH_W-1:0] wep;
    } ent_t;

    ent_t ents     [ENTRIES];
    ent_t ents_nxt [ENTRIES];

    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_vec;
    logic                          hit;
    logic                          room;
    logic [IDX_W-1:0]              hit_idx;
    logic [IDX_W-1:0]              room_idx;
    logic [IDX_W-1:0]              tgt_idx;

    logic                          walking;
    logic [IDX_W-1:0]              walk_idx;
    logic [EPOCH_W-1:0]            cur_ep;
    logic [EPOCH_W-1:0]            commit_ep;
    logic                          rec_apply;

    logic                          avail;
    logic [SLOT_W-1:0]             grant_idx;
    logic [SLOTS-1:0]              grant_mask;
    logic [SLOTS-1:0]              alloc_mask;
    logic [SLOTS-1:0]              free_mask;

    wr_kind_e                      kind;
    logic                          need_slot;
    logic                          acc;
    logic                          wr_acc;
    logic [SLOT_W-1:0]             res_slot;

    // Flatten entry state for the lookup
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign valid_vec[g] = ents[g].valid;
        assign tag_vec[g]   = ents[g].tag;
    end

    ckrt_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .valid_vec (valid_vec),
        .tag_vec   (tag_vec),
        .key       (req_tag),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .room      (room),
        .room_idx  (room_idx)
    );

    ckrt_commit_seq #(.ENTRIES(ENTRIES), .EPOCH_W(EPOCH_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_req  (commit_req),
        .recover_req (recover_req),
        .walking     (walking),
        .walk_idx    (walk_idx),
        .cur_ep      (cur_ep),
        .commit_ep   (commit_ep),
        .rec_apply   (rec_apply),
        .busy        (busy)
    );

    ckrt_slot_alloc #(.SLOTS(SLOTS)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_mask  (alloc_mask),
        .free_mask  (free_mask),
        .avail      (avail),
        .grant_idx  (grant_idx),
        .grant_mask (grant_mask)
    );

    // Classify the write against the targeted entry
    always_comb begin
        if (!hit)
            kind = WK_NEW;
        else if (ents[hit_idx].pend && ents[hit_idx].wep == cur_ep)
            kind = WK_IN_PLACE;
        else if (ents[hit_idx].pend)
            kind = WK_FOLD;
        else
            kind = WK_REMAP;
    end

    // Acceptance and slot consumption
    always_comb begin
        need_slot  = (kind != WK_IN_PLACE);
        req_ready  = !rec_apply &&
                     (!req_write || ((!need_slot || avail) && (hit || room)));
        acc        = req_valid && req_ready;
        wr_acc     = acc && req_write;
        alloc_mask = (wr_acc && need_slot) ? grant_mask : '0;
        tgt_idx    = hit ? hit_idx : room_idx;
    end

    // Slot reported in the response
    always_comb begin
        if (!req_write)
            res_slot = !hit ? '0 :
                       (ents[hit_idx].pend ? ents[hit_idx].wslot : ents[hit_idx].cslot);
        else if (kind == WK_IN_PLACE)
            res_slot = ents[hit_idx].wslot;
        else
            res_slot = grant_idx;
    end

    // Next entry state from recovery, the write and the commit walk
    always_comb begin
        free_mask = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            ents_nxt[i] = ents[i];
            if (rec_apply) begin
                if (ents[i].valid && ents[i].pend) begin
                    free_mask[ents[i].wslot] = 1'b1;
                    ents_nxt[i].pend = 1'b0;
                    if (ents[i].cvalid) ents_nxt[i].wslot = ents[i].cslot;
                    else                ents_nxt[i].valid = 1'b0;
                end
            end else if (wr_acc && tgt_idx == IDX_W'(i)) begin
                unique case (kind)
                    WK_NEW: begin
                        ents_nxt[i].valid  = 1'b1;
                        ents_nxt[i].tag    = req_tag;
                        ents_nxt[i].wslot  = grant_idx;
                        ents_nxt[i].cslot  = grant_idx;
                        ents_nxt[i].cvalid = 1'b0;
                        ents_nxt[i].pend   = 1'b1;
                        ents_nxt[i].wep    = cur_ep;
                    end
                    WK_IN_PLACE: begin
                        ents_nxt[i].wep = cur_ep;
                    end
                    WK_REMAP: begin
                        ents_nxt[i].wslot = grant_idx;
                        ents_nxt[i].pend  = 1'b1;
                        ents_nxt[i].wep   = cur_ep;
                    end
                    WK_FOLD: begin
                        if (ents[i].cvalid) free_mask[ents[i].cslot] = 1'b1;
                        ents_nxt[i].cslot  = ents[i].wslot;
                        ents_nxt[i].cvalid = 1'b1;
                        ents_nxt[i].wslot  = grant_idx;
                        ents_nxt[i].pend   = 1'b1;
                        ents_nxt[i].wep    = cur_ep;
                    end
                endcase
            end else if (walking && walk_idx == IDX_W'(i) && ents[i].valid &&
                         ents[i].pend && ents[i].wep == commit_ep) begin
                if (ents[i].cvalid) free_mask[ents[i].cslot] = 1'b1;
                ents_nxt[i].cslot  = ents[i].wslot;
                ents_nxt[i].cvalid = 1'b1;
                ents_nxt[i].pend   = 1'b0;
            end
        end
    end

    // Entry storage
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) ents[i] <= '0;
            else        ents[i] <= ents_nxt[i];
        end
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_slot  <= '0;
        end else begin
            rsp_valid <= acc;
            rsp_hit   <= acc && hit;
            rsp_slot  <= acc ? res_slot : '0;
        end
    end

endmodule

// File: rtl/ckrt_checker.sv
// Protocol checks for the remap table, attached by bind.
module ckrt_checker #(
    parameter int SLOTS = 32
)(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             commit_req,
    input logic             busy,
    input logic [SLOTS-1:0] alloc_mask
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !rsp_valid));

    // R2
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid && req_ready)));

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_mask));

    // R5
    commit_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !busy) |=> busy);

    // R8
    held_commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && busy) |=> busy);

    // R11
    stall_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !rsp_valid);

endmodule

bind ckpt_remap_table ckrt_checker #(.SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .commit_req (commit_req),
    .busy       (busy),
    .alloc_mask (alloc_mask)
);

// File: tb/sim_ckpt_remap_table.sv
// Directed bench for the checkpointing remap table.
module sim_ckpt_remap_table;

    localparam int ENT = 16;
    localparam int SL  = 8;
    localparam int TW  = 8;
    localparam int EW  = 3;
    localparam int SW  = $clog2(SL);

    logic          clk;
    logic          rst_n;
    logic          req_valid;
    logic          req_write;
    logic [TW-1:0] req_tag;
    logic          req_ready;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [SW-1:0] rsp_slot;
    logic          commit_req;
    logic          recover_req;
    logic          busy;

    int checks;
    int fails;
    int busy_cnt;

    ckpt_remap_table #(.ENTRIES(ENT), .SLOTS(SL), .TAG_W(TW), .EPOCH_W(EW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_tag     (req_tag),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_slot    (rsp_slot),
        .commit_req  (commit_req),
        .recover_req (recover_req),
        .busy        (busy)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic check(input string rid, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rid, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int tag, input int exp_hit,
                          input int exp_slot, input string rid);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_tag   = TW'(tag);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(rid, int'(rsp_valid), 1);
        check(rid, int'(rsp_hit), exp_hit);
        if (exp_slot >= 0) check(rid, int'(rsp_slot), exp_slot);
    endtask

    task automatic pulse_commit();
        @(negedge clk);
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
    endtask

    task automatic pulse_recover();
        @(negedge clk);
        recover_req = 1'b1;
        @(negedge clk);
        recover_req = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        check("R1 busy", int'(busy), 0);
        check("R1 rsp_valid", int'(rsp_valid), 0);
        check("R1 req_ready", int'(req_ready), 1);
    endtask

    // R2 R3 R4: allocation, in-place rewrite, read selection
    task automatic t_basic();
        access(1, 5, 0, 0, "R2 first write slot");
        access(1, 5, 1, 0, "R3 same-epoch rewrite");
        access(0, 5, 1, 0, "R4 read working");
        access(0, 9, 0, -1, "R4 untracked read");
        access(1, 6, 0, 1, "R2 second tag lowest free");
    endtask

    // R5 R6: commit walk length, promotion and freeing
    task automatic t_commit();
        busy_cnt = 0;
        pulse_commit();
        wait_idle();
        check("R5 walk cycles", busy_cnt, ENT);
        access(0, 5, 1, 0, "R4 read checkpoint");
        access(1, 5, 1, 2, "R6 remap after commit");
        access(0, 5, 1, 2, "R4 read new working");
        pulse_commit();
        wait_idle();
        access(1, 6, 1, 0, "R5 old checkpoint freed");
    endtask

    // R9: idle recovery
    task automatic t_recover();
        pulse_recover();
        access(0, 6, 1, 1, "R9 rollback to checkpoint");
        access(1, 7, 0, 0, "R9 freed working slot reused");
        pulse_recover();
        access(0, 7, 0, -1, "R9 never-committed untracked");
        access(0, 5, 1, 2, "R9 committed block unchanged");
    endtask

    // R7 R8: writes during a walk and a held second commit
    task automatic t_overlap();
        access(1, 7, 0, 0, "R2 retrack tag");
        busy_cnt = 0;
        pulse_commit();
        access(1, 5, 1, 3, "R7 write during walk");
        check("R7 busy during write", int'(busy), 1);
        access(1, 7, 1, 4, "R7 write on walked block");
        pulse_commit();
        wait_idle();
        check("R8 held commit busy cycles", busy_cnt, 2 * ENT);
        access(1, 6, 1, 0, "R8 both walks freed");
        access(0, 5, 1, 3, "R8 promoted checkpoint");
        access(0, 7, 1, 4, "R8 promoted checkpoint");
    endtask

    // R10: recovery queued behind a walk
    task automatic t_late_recover();
        pulse_commit();
        pulse_recover();
        access(1, 6, 1, 1, "R10 write during walk");
        wait_idle();
        access(0, 6, 1, 0, "R10 committed copy kept");
        access(1, 6, 1, 1, "R10 discarded slot returned");
    endtask

    // R11: empty pool back-pressure released by a commit
    task automatic t_backpressure();
        do_reset();
        access(0, 5, 0, -1, "R1 table empty after reset");
        for (int t = 0; t < 4; t++) access(1, 10 + t, 0, t, "R2 fill");
        pulse_commit();
        wait_idle();
        for (int t = 0; t < 4; t++) access(1, 10 + t, 1, 4 + t, "R6 fill remap");
        access(1, 10, 1, 4, "R3 rewrite with empty pool");
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_tag   = TW'(14);
        #1;
        check("R11 ready low", int'(req_ready), 0);
        @(negedge clk);
        check("R11 no response", int'(rsp_valid), 0);
        check("R11 still stalled", int'(req_ready), 0);
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 accepted", int'(rsp_valid), 1);
        check("R11 freed slot", int'(rsp_slot), 0);
        wait_idle();
    endtask

    initial begin
        checks      = 0;
        fails       = 0;
        busy_cnt    = 0;
        rst_n       = 1'b0;
        req_valid   = 1'b0;
        req_write   = 1'b0;
        req_tag     = '0;
        commit_req  = 1'b0;
        recover_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_commit();
        t_recover();
        t_overlap();
        t_late_recover();
        t_backpressure();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule